// File: doc/BRIEF.md
# DDR Command Decoder with Power States

This block sits behind the command pins of a double-data-rate memory device model or controller front end. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable, along with clock enable, the bank address and address bit 10. It turns these into one registered one-hot command word and a set of qualifiers: the bank index, the auto-precharge and precharge-all flags, the mode-register target, and an illegal-command flag.

The decoder also tracks a device-level power state: normal (idle or active), power-down, self-refresh, and a self-refresh recovery window. Because the current and the previous clock-enable values and the power state all take part in decoding, one pin pattern can mean a different action in a different state. A per-bank active vector is supplied from outside and is used for the all-banks-idle checks. A second input says whether a read burst without auto-precharge is in progress, which is the only case where burst terminate is legal.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and forces the power state to normal (code 0). Previous clock enable is taken as high after reset.
- R2: With chip select high (deselect), or chip select low and row/column/write strobes all high, the command is NOP, which is one-hot bit 0.
- R3: In the normal state with clock enable high on the previous and current edge, strobes {ras,cas,we} decode as follows. 011 is activate (bit 1). 101 is read (bit 2). 100 is write (bit 3). 010 is precharge (bit 4). 110 is burst terminate (bit 5). 001 is auto-refresh (bit 6). 000 is mode-register set (bit 7).
- R4: Address bit 10 high on a read or write sets the auto-precharge flag. On a precharge it sets the precharge-all flag. Both flags are low for every other command.
- R5: A mode-register set with bank address 0 sets target bit 0 (base register). With bank address 1 it sets target bit 1 (extended register). Any other bank address, or any bank active, makes it illegal.
- R6: Burst terminate is legal only while the read-burst-without-auto-precharge input is high. Otherwise it is illegal.
- R7: Auto-refresh with any bank active is illegal.
- R8: All outputs are registered and appear the cycle after the sampling edge. The bank index carries the bank address for activate, read, write, precharge and mode-register set, and is 0 for every other command.
- R9: In normal state with all banks idle, a falling clock enable with NOP or deselect enters power-down (state 1, bit 10). Clock enable low holds power-down with NOP whatever the other pins are. Clock enable high exits to normal (bit 11).
- R10: In normal state with all banks idle, a falling clock enable with the auto-refresh pattern enters self-refresh (state 2, bit 8). Clock enable low holds it with NOP, ignoring all other pins.
- R11: In self-refresh, clock enable high with NOP or deselect exits (bit 9) into recovery (state 3). Recovery lasts exactly TRFC_CYC cycles before normal. Clock enable high with any other command is illegal and self-refresh is kept.
- R12: During recovery, anything other than NOP or deselect with clock enable high is flagged illegal and the state is unaffected.
- R13: In normal state, a falling clock enable with any bank active, or with a pattern other than NOP, deselect or auto-refresh, is illegal and the state is kept. The next edge decodes as NOP because the previous clock enable was low.
- R14: An illegal command yields a zero one-hot word, bank index 0, and all flags and targets low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 |
| bank_active | input | NUM_BANKS | Per-bank active flags |
| rd_burst_noap | input | 1 | Read burst without auto-precharge in progress |
| cmd_oh | output | 12 | One-hot decoded command |
| cmd_bank | output | BA_W | Bank index of the command |
| auto_pre | output | 1 | Auto-precharge requested |
| pre_all | output | 1 | Precharge all banks |
| mr_sel | output | 2 | Mode register target, bit 0 base, bit 1 extended |
| illegal | output | 1 | Illegal command in current state |
| pwr_state | output | 2 | 0 normal, 1 power-down, 2 self-refresh, 3 recovery |

## Verification
The bench sweeps every chip-select and strobe pattern against all bank addresses, both A10 values, idle and busy banks, and both burst-terminate qualifier values. A decoder that swapped a strobe code, leaked A10 into the wrong flag, or let terminate, refresh or reserved mode-register targets through would report a wrong one-hot bit or miss the illegal flag. Directed sequences cover the power state boundaries. These include a clock-enable fall while a bank is busy, which a careless design would let into power-down, and a non-NOP command at self-refresh exit, which it would accept. The recovery window is counted cycle by cycle, so a counter that is off by one shows up as an early or late return to normal.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  localparam int CMD_N = 12;

  typedef enum logic [3:0] {
    C_NOP   = 4'd0,
    C_ACT   = 4'd1,
    C_RD    = 4'd2,
    C_WR    = 4'd3,
    C_PRE   = 4'd4,
    C_TERM  = 4'd5,
    C_REF   = 4'd6,
    C_MRS   = 4'd7,
    C_SRIN  = 4'd8,
    C_SROUT = 4'd9,
    C_PDIN  = 4'd10,
    C_PDOUT = 4'd11
  } cmd_e;

  typedef enum logic [1:0] {
    PS_NORM  = 2'd0,
    PS_PDN   = 2'd1,
    PS_SREF  = 2'd2,
    PS_SRREC = 2'd3
  } pwr_e;

  typedef enum logic [2:0] {
    P_NOP  = 3'd0,
    P_ACT  = 3'd1,
    P_RD   = 3'd2,
    P_WR   = 3'd3,
    P_PRE  = 3'd4,
    P_TERM = 3'd5,
    P_REF  = 3'd6,
    P_MRS  = 3'd7
  } pat_e;

endpackage

// File: rtl/ddr_pin_decode.sv
module ddr_pin_decode
  import ddr_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output pat_e pat
);

  always_comb begin
    pat = P_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: pat = P_NOP;
        3'b011: pat = P_ACT;
        3'b101: pat = P_RD;
        3'b100: pat = P_WR;
        3'b010: pat = P_PRE;
        3'b110: pat = P_TERM;
        3'b001: pat = P_REF;
        3'b000: pat = P_MRS;
        default: pat = P_NOP;
      endcase
    end
  end

endmodule

// File: rtl/ddr_cmd_qualify.sv
module ddr_cmd_qualify
  import ddr_cmd_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  pat_e            pat,
  input  pwr_e            state,
  input  logic            cke,
  input  logic            cke_prev,
  input  logic            all_idle,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  input  logic            rd_burst_noap,
  output cmd_e            cmd,
  output logic            ill,
  output logic            use_bank,
  output logic            ap,
  output logic            pa,
  output logic [1:0]      mr,
  output logic            go_pd,
  output logic            go_sr,
  output logic            leave_pd,
  output logic            leave_sr
);

  logic is_nop;
  logic mr_base;
  logic mr_ext;

  assign is_nop  = (pat == P_NOP);
  assign mr_base = (ba == BA_W'(0));
  assign mr_ext  = (ba == BA_W'(1));

  always_comb begin
    cmd      = C_NOP;
    ill      = 1'b0;
    use_bank = 1'b0;
    ap       = 1'b0;
    pa       = 1'b0;
    mr       = 2'b00;
    go_pd    = 1'b0;
    go_sr    = 1'b0;
    leave_pd = 1'b0;
    leave_sr = 1'b0;
    unique case (state)
      PS_NORM: begin
        if (!cke_prev) begin
          cmd = C_NOP;
        end else if (cke) begin
          unique case (pat)
            P_NOP: cmd = C_NOP;
            P_ACT: begin
              cmd      = C_ACT;
              use_bank = 1'b1;
            end
            P_RD: begin
              cmd      = C_RD;
              use_bank = 1'b1;
              ap       = a10;
            end
            P_WR: begin
              cmd      = C_WR;
              use_bank = 1'b1;
              ap       = a10;
            end
            P_PRE: begin
              cmd      = C_PRE;
              use_bank = 1'b1;
              pa       = a10;
            end
            P_TERM: begin
              if (rd_burst_noap) cmd = C_TERM;
              else               ill = 1'b1;
            end
            P_REF: begin
              if (all_idle) cmd = C_REF;
              else          ill = 1'b1;
            end
            P_MRS: begin
              if (all_idle && (mr_base || mr_ext)) begin
                cmd      = C_MRS;
                use_bank = 1'b1;
                mr       = {mr_ext, mr_base};
              end else begin
                ill = 1'b1;
              end
            end
            default: ill = 1'b1;
          endcase
        end else begin
          if (!all_idle) begin
            ill = 1'b1;
          end else if (pat == P_REF) begin
            cmd   = C_SRIN;
            go_sr = 1'b1;
          end else if (is_nop) begin
            cmd   = C_PDIN;
            go_pd = 1'b1;
          end else begin
            ill = 1'b1;
          end
        end
      end
      PS_PDN: begin
        if (cke) begin
          cmd      = C_PDOUT;
          leave_pd = 1'b1;
        end
      end
      PS_SREF: begin
        if (cke) begin
          if (is_nop) begin
            cmd      = C_SROUT;
            leave_sr = 1'b1;
          end else begin
            ill = 1'b1;
          end
        end
      end
      PS_SRREC: begin
        if (!cke || !is_nop) ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
    if (ill) cmd = C_NOP;
  end

endmodule

// File: rtl/ddr_pwr_fsm.sv
module ddr_pwr_fsm
  import ddr_cmd_pkg::*;
#(
  parameter int TRFC_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic cke,
  input  logic go_pd,
  input  logic go_sr,
  input  logic leave_pd,
  input  logic leave_sr,
  output pwr_e state,
  output logic cke_prev
);

  localparam int CNT_W = (TRFC_CYC > 1) ? $clog2(TRFC_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRFC_CYC - 1);

  logic [CNT_W-1:0] rec_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_NORM;
      rec_cnt  <= '0;
      cke_prev <= 1'b1;
    end else begin
      cke_prev <= cke;
      unique case (state)
        PS_NORM: begin
          if (go_sr)      state <= PS_SREF;
          else if (go_pd) state <= PS_PDN;
        end
        PS_PDN: begin
          if (leave_pd) state <= PS_NORM;
        end
        PS_SREF: begin
          if (leave_sr) begin
            state   <= PS_SRREC;
            rec_cnt <= CNT_LOAD;
          end
        end
        PS_SRREC: begin
          if (rec_cnt == '0) state <= PS_NORM;
          else               rec_cnt <= rec_cnt - 1'b1;
        end
        default: state <= PS_NORM;
      endcase
    end
  end

endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRFC_CYC  = 6,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] bank_active,
  input  logic                 rd_burst_noap,
  output logic [CMD_N-1:0]     cmd_oh,
  output logic [BA_W-1:0]      cmd_bank,
  output logic                 auto_pre,
  output logic                 pre_all,
  output logic [1:0]           mr_sel,
  output logic                 illegal,
  output logic [1:0]           pwr_state
);

  pat_e            pat;
  pwr_e            state;
  cmd_e            cmd;
  logic            cke_prev;
  logic            all_idle;
  logic            ill;
  logic            use_bank;
  logic            ap;
  logic            pa;
  logic [1:0]      mr;
  logic            go_pd;
  logic            go_sr;
  logic            leave_pd;
  logic            leave_sr;
  logic [CMD_N-1:0] oh_next;

  assign all_idle = ~|bank_active;

  ddr_pin_decode pin_i (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .pat   (pat)
  );

  ddr_cmd_qualify #(.BA_W(BA_W)) qual_i (
    .pat           (pat),
    .state         (state),
    .cke           (cke),
    .cke_prev      (cke_prev),
    .all_idle      (all_idle),
    .ba            (ba),
    .a10           (a10),
    .rd_burst_noap (rd_burst_noap),
    .cmd           (cmd),
    .ill           (ill),
    .use_bank      (use_bank),
    .ap            (ap),
    .pa            (pa),
    .mr            (mr),
    .go_pd         (go_pd),
    .go_sr         (go_sr),
    .leave_pd      (leave_pd),
    .leave_sr      (leave_sr)
  );

  ddr_pwr_fsm #(.TRFC_CYC(TRFC_CYC)) pwr_i (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .go_pd    (go_pd),
    .go_sr    (go_sr),
    .leave_pd (leave_pd),
    .leave_sr (leave_sr),
    .state    (state),
    .cke_prev (cke_prev)
  );

  genvar gi;
  generate
    for (gi = 0; gi < CMD_N; gi++) begin : g_oh
      assign oh_next[gi] = !ill && (cmd == cmd_e'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_oh   <= '0;
      cmd_bank <= '0;
      auto_pre <= 1'b0;
      pre_all  <= 1'b0;
      mr_sel   <= 2'b00;
      illegal  <= 1'b0;
    end else begin
      cmd_oh   <= oh_next;
      cmd_bank <= use_bank ? ba : '0;
      auto_pre <= ap;
      pre_all  <= pa;
      mr_sel   <= mr;
      illegal  <= ill;
    end
  end

  assign pwr_state = state;

endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
  parameter int NUM_BANKS = 4,
  parameter int TRFC_CYC  = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic [11:0]          cmd_oh,
  input logic                 auto_pre,
  input logic                 pre_all,
  input logic [1:0]           mr_sel,
  input logic                 illegal,
  input logic [1:0]           pwr_state
);

  int unsigned rec_seen;

  always_ff @(posedge clk) begin
    if (rst) rec_seen <= 0;
    else     rec_seen <= (pwr_state == 2'd3) ? rec_seen + 1 : 0;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pwr_state == 2'd0 && cmd_oh == '0 && !illegal));

  // R14
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (cmd_oh == '0 && !auto_pre && !pre_all && mr_sel == 2'b00));

  // R3
  legal_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!illegal && !$past(rst)) |-> $onehot(cmd_oh));

  // R4
  auto_pre_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    auto_pre |-> (cmd_oh[2] || cmd_oh[3]));

  // R4
  pre_all_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    pre_all |-> cmd_oh[4]);

  // R9
  pd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd1 && $past(pwr_state) != 2'd1) |->
      (cmd_oh[10] && $past(bank_active) == '0));

  // R9
  pd_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_state) == 2'd1 && pwr_state != 2'd1) |->
      (pwr_state == 2'd0 && cmd_oh[11]));

  // R10
  sr_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd2 && $past(pwr_state) != 2'd2) |->
      (cmd_oh[8] && $past(bank_active) == '0));

  // R11
  sr_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_state) == 2'd2 && pwr_state != 2'd2) |->
      (pwr_state == 2'd3 && cmd_oh[9]));

  // R11
  rec_len_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3) |-> (rec_seen < TRFC_CYC));

  // R11
  rec_done_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pwr_state) == 2'd3 && pwr_state != 2'd3) |->
      (pwr_state == 2'd0 && rec_seen == TRFC_CYC));

  // R12
  rec_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3 && $past(pwr_state) == 2'd3) |->
      (cmd_oh == 12'd0 || cmd_oh == 12'd1));

endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(
  .NUM_BANKS (NUM_BANKS),
  .TRFC_CYC  (TRFC_CYC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bank_active (bank_active),
  .cmd_oh      (cmd_oh),
  .auto_pre    (auto_pre),
  .pre_all     (pre_all),
  .mr_sel      (mr_sel),
  .illegal     (illegal),
  .pwr_state   (pwr_state)
);

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TRFC       = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        ras_n = 1'b1;
  logic        cas_n = 1'b1;
  logic        we_n = 1'b1;
  logic        cke = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic        a10 = 1'b0;
  logic [3:0]  bank_active = 4'd0;
  logic        rd_burst_noap = 1'b0;
  logic [11:0] cmd_oh;
  logic [1:0]  cmd_bank;
  logic        auto_pre;
  logic        pre_all;
  logic [1:0]  mr_sel;
  logic        illegal;
  logic [1:0]  pwr_state;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_decoder #(.NUM_BANKS(4), .TRFC_CYC(TRFC)) dut_i (
    .clk (clk), .rst (rst), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .cke (cke), .ba (ba), .a10 (a10),
    .bank_active (bank_active), .rd_burst_noap (rd_burst_noap),
    .cmd_oh (cmd_oh), .cmd_bank (cmd_bank), .auto_pre (auto_pre),
    .pre_all (pre_all), .mr_sel (mr_sel), .illegal (illegal),
    .pwr_state (pwr_state)
  );

  task automatic drv(input logic cs, input logic [2:0] p, input logic k,
                     input logic [1:0] b, input logic a, input logic [3:0] bk,
                     input logic rb);
    cs_n = cs; {ras_n, cas_n, we_n} = p; cke = k; ba = b; a10 = a;
    bank_active = bk; rd_burst_noap = rb;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [11:0] eoh, input logic [1:0] ebk,
                     input logic eap, input logic epa, input logic [1:0] emr,
                     input logic eill, input logic [1:0] eps);
    total++;
    if (cmd_oh !== eoh || cmd_bank !== ebk || auto_pre !== eap || pre_all !== epa ||
        mr_sel !== emr || illegal !== eill || pwr_state !== eps) begin
      fails++;
      $display("FAIL %s: actual oh=%h bk=%0d ap=%0b pa=%0b mr=%b ill=%0b ps=%0d expected oh=%h bk=%0d ap=%0b pa=%0b mr=%b ill=%0b ps=%0d",
               tag, cmd_oh, cmd_bank, auto_pre, pre_all, mr_sel, illegal, pwr_state,
               eoh, ebk, eap, epa, emr, eill, eps);
    end
  endtask

  function automatic logic [11:0] bit_of(input int n);
    return 12'd1 << n;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    total++; fails++;
    $display("FAIL R1 watchdog: actual run not finished expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 12'd0, 2'd0, 0, 0, 2'b00, 0, 2'd0);
    rst = 1'b0;

    // exhaustive sweep in normal state, cke high on both edges
    for (int cs = 0; cs < 2; cs++)
      for (int p = 0; p < 8; p++)
        for (int b = 0; b < 4; b++)
          for (int a = 0; a < 2; a++)
            for (int bk = 0; bk < 2; bk++)
              for (int rb = 0; rb < 2; rb++) begin
                logic [11:0] eoh;
                logic [1:0]  ebk;
                logic        eap, epa, eill;
                logic [1:0]  emr;
                string       tag;
                logic        idle;
                idle = (bk == 0);
                eoh = 12'd0; ebk = 2'd0; eap = 0; epa = 0; eill = 0; emr = 2'b00;
                tag = "R2";
                if (cs == 1 || p == 7) begin
                  eoh = bit_of(0);
                end else begin
                  case (p)
                    3: begin eoh = bit_of(1); ebk = 2'(b); tag = "R3"; end
                    5: begin eoh = bit_of(2); ebk = 2'(b); eap = 1'(a); tag = "R4"; end
                    4: begin eoh = bit_of(3); ebk = 2'(b); eap = 1'(a); tag = "R4"; end
                    2: begin eoh = bit_of(4); ebk = 2'(b); epa = 1'(a); tag = "R4"; end
                    6: begin tag = "R6"; if (rb == 1) eoh = bit_of(5); else eill = 1; end
                    1: begin tag = "R7"; if (idle) eoh = bit_of(6); else eill = 1; end
                    default: begin
                      tag = "R5";
                      if (idle && b < 2) begin
                        eoh = bit_of(7); ebk = 2'(b);
                        emr = (b == 0) ? 2'b01 : 2'b10;
                      end else eill = 1;
                    end
                  endcase
                end
                drv(1'(cs), 3'(p), 1'b1, 2'(b), 1'(a), idle ? 4'd0 : 4'b0100, 1'(rb));
                chk(tag, eoh, ebk, eap, epa, emr, eill, 2'd0);
              end

    // R8: bank index follows command then returns to zero
    drv(0, 3'b011, 1, 2'd3, 0, 4'd0, 0);
    chk("R8", bit_of(1), 2'd3, 0, 0, 2'b00, 0, 2'd0);
    drv(0, 3'b111, 1, 2'd2, 1, 4'd0, 0);
    chk("R8", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd0);

    // R14: illegal terminate clears all qualifiers
    drv(0, 3'b110, 1, 2'd3, 1, 4'd0, 0);
    chk("R14", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd0);

    // R9: power-down entry, hold, exit
    drv(1, 3'b000, 0, 2'd1, 0, 4'd0, 0);
    chk("R9", bit_of(10), 2'd0, 0, 0, 2'b00, 0, 2'd1);
    for (int i = 0; i < 3; i++) begin
      drv(0, 3'(5 - i), 0, 2'(i), 1, 4'd0, 1);
      chk("R9", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd1);
    end
    drv(0, 3'b100, 1, 2'd1, 1, 4'd0, 0);
    chk("R9", bit_of(11), 2'd0, 0, 0, 2'b00, 0, 2'd0);
    drv(0, 3'b101, 1, 2'd2, 0, 4'd0, 0);
    chk("R9", bit_of(2), 2'd2, 0, 0, 2'b00, 0, 2'd0);

    // R13: cke fall with bank active, then prior-low edge decodes NOP
    drv(0, 3'b111, 0, 2'd0, 0, 4'b0001, 0);
    chk("R13", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd0);
    drv(0, 3'b101, 1, 2'd1, 0, 4'b0001, 0);
    chk("R13", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd0);
    drv(0, 3'b101, 1, 2'd1, 0, 4'b0001, 0);
    chk("R13", bit_of(2), 2'd1, 0, 0, 2'b00, 0, 2'd0);
    // R13: cke fall with an activate pattern while idle
    drv(0, 3'b011, 0, 2'd2, 0, 4'd0, 0);
    chk("R13", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd0);
    drv(1, 3'b111, 1, 2'd0, 0, 4'd0, 0);
    chk("R13", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd0);

    // R10: self-refresh entry and hold
    drv(0, 3'b001, 0, 2'd0, 0, 4'd0, 0);
    chk("R10", bit_of(8), 2'd0, 0, 0, 2'b00, 0, 2'd2);
    for (int i = 0; i < 3; i++) begin
      drv(0, 3'(i), 0, 2'(3 - i), 1, 4'd0, 1);
      chk("R10", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd2);
    end

    // R11: read at exit is illegal, deselect exits into recovery
    drv(0, 3'b101, 1, 2'd1, 0, 4'd0, 0);
    chk("R11", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd2);
    drv(1, 3'b000, 1, 2'd0, 0, 4'd0, 0);
    chk("R11", bit_of(9), 2'd0, 0, 0, 2'b00, 0, 2'd3);
    drv(0, 3'b111, 1, 2'd0, 0, 4'd0, 0);
    chk("R11", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd3);
    // R12: commands during recovery
    drv(0, 3'b011, 1, 2'd1, 0, 4'd0, 0);
    chk("R12", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd3);
    drv(0, 3'b111, 0, 2'd0, 0, 4'd0, 0);
    chk("R12", 12'd0, 2'd0, 0, 0, 2'b00, 1, 2'd3);
    drv(1, 3'b111, 1, 2'd0, 0, 4'd0, 0);
    chk("R11", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd3);
    drv(1, 3'b111, 1, 2'd0, 0, 4'd0, 0);
    chk("R11", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd3);
    drv(1, 3'b111, 1, 2'd0, 0, 4'd0, 0);
    chk("R11", bit_of(0), 2'd0, 0, 0, 2'b00, 0, 2'd0);
    drv(0, 3'b101, 1, 2'd3, 1, 4'd0, 0);
    chk("R11", bit_of(2), 2'd3, 1, 0, 2'b00, 0, 2'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule